// File: doc/BRIEF.md
# Persistent Write-Per-Bit Mask Unit

This block supplies the per-bit write enable for a 16-bit DRAM data path. A masked write cycle is one in which write-enable is low when the row strobe falls. In such a cycle each data bit is written only if its mask bit is 1. The mask comes from one of two sources. In the default mode, the value on the data bus is captured as the mask at the row-strobe fall. In sticky mode, the block uses a stored mask that was loaded earlier by a dedicated load command.

The surrounding controller decodes the cycle type and hands this unit single-cycle event pulses:
- row-strobe fall, together with the sampled write-enable level;
- row-strobe rise;
- mask load;
- mask-reset refresh.

The unit keeps the chosen mask for the whole row-active period, so every page-mode column access uses it. It gates the mask with the two byte-lane column strobes and drives one enable per data bit.

Top module: `wpb_mask_unit`

## Requirements
- R1: After reset, sticky mode is off, no masked cycle is open, the cycle mask is all ones, and `wr_en_o` equals the byte-lane expansion. Sticky mode is also off after a reset that follows a mask load.
- R2: A row-strobe fall with `we_low_i` = 0 opens an unmasked cycle. The mask becomes all ones and `masked_cycle_o` is 0, whether or not sticky mode is on.
- R3: A row-strobe fall with `we_low_i` = 1 while sticky mode is off captures `dq_i` as the mask and sets `masked_cycle_o`. A mask bit of 1 lets that data bit write, and a mask bit of 0 blocks it.
- R4: Between a row-strobe fall and the next row-strobe rise, the mask does not change, whatever `dq_i` does during page accesses.
- R5: A mask-load pulse stores `dq_i` as the sticky mask and sets `persist_mode_o`.
- R6: In sticky mode, a masked row-strobe fall takes the stored mask and ignores `dq_i`.
- R7: A mask-reset pulse clears `persist_mode_o`. Later masked cycles take their mask from `dq_i` again.
- R8: Unmasked cycles and masked cycles leave the stored sticky mask unchanged.
- R9: `wr_en_o` is the mask ANDed with the lanes. `lane_en_i[0]` gates bits 7:0 and `lane_en_i[1]` gates bits 15:8.
- R10: A row-strobe rise closes the cycle. The mask returns to all ones and `masked_cycle_o` to 0.
- R11: If mask load and mask reset arrive in the same cycle, mask reset wins. Sticky mode ends off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_fall_i | input | 1 | Row-strobe falling-edge event pulse |
| we_low_i | input | 1 | Write-enable was low at that row-strobe fall |
| ras_rise_i | input | 1 | Row-strobe rising-edge event pulse |
| load_mask_i | input | 1 | Mask-load command pulse |
| mask_reset_i | input | 1 | Mask-reset refresh cycle pulse |
| dq_i | input | 16 | Data bus, sampled as a mask |
| lane_en_i | input | 2 | Byte-lane column strobes, bit 0 is the low byte |
| wr_en_o | output | 16 | Per-bit write enable |
| persist_mode_o | output | 1 | Sticky mask mode is active |
| masked_cycle_o | output | 1 | The current row cycle is masked |

## Verification
The assertions check the following on every cycle:
- mask-source selection at each row-strobe fall;
- the mask holding steady between row events;
- the all-ones restore at row-strobe rise;
- the sticky flag's set, clear and priority rules;
- that no enabled bit escapes the mask.

Some behaviour needs ordered sequences of events, and only the bench scenarios can show it. One case is a stored mask that survives several unmasked and masked cycles. Another is the return to data-bus sourcing after a mask reset. Two more are byte-lane patterns combined with page-mode bus changes, and reset clearing a previously loaded mode.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = DATA_W / LANE_W;

  // Spread one enable per byte lane over its data bits.
  function automatic logic [DATA_W-1:0] lane_expand(input logic [LANES-1:0] lanes);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = lanes[i / LANE_W];
    return r;
  endfunction

  // Mask chosen at a row-strobe fall.
  function automatic logic [DATA_W-1:0] pick_mask(input logic masked, input logic sticky,
                                                  input logic [DATA_W-1:0] stored,
                                                  input logic [DATA_W-1:0] bus);
    if (!masked) return {DATA_W{1'b1}};
    return sticky ? stored : bus;
  endfunction
endpackage

// File: rtl/wpb_persist_store.sv
module wpb_persist_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] data_i,
  output logic         persist_o,
  output logic [W-1:0] store_o
);
  // Clear has priority over load.
  logic do_load;
  assign do_load = load_i & ~clear_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      persist_o <= 1'b0;
      store_o   <= {W{1'b1}};
    end else begin
      if (clear_i)      persist_o <= 1'b0;
      else if (load_i)  persist_o <= 1'b1;
      if (do_load)      store_o   <= data_i;
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !persist_o);
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (persist_o && store_o == $past(data_i)));
  assert_store_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i || clear_i) |=> $stable(store_o));
endmodule

// File: rtl/wpb_cycle_mask.sv
module wpb_cycle_mask #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ras_fall_i,
  input  logic         we_low_i,
  input  logic         ras_rise_i,
  input  logic         persist_i,
  input  logic [W-1:0] store_i,
  input  logic [W-1:0] dq_i,
  output logic [W-1:0] mask_o,
  output logic         masked_o
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o   <= ONES;
      masked_o <= 1'b0;
    end else if (ras_fall_i) begin
      mask_o   <= wpb_pkg::pick_mask(we_low_i, persist_i, store_i, dq_i);
      masked_o <= we_low_i;
    end else if (ras_rise_i) begin
      mask_o   <= ONES;
      masked_o <= 1'b0;
    end
  end

  assert_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall_i && !we_low_i) |=> (mask_o == ONES && !masked_o));
  assert_new_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall_i && we_low_i && !persist_i) |=> (mask_o == $past(dq_i) && masked_o));
  assert_sticky_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall_i && we_low_i && persist_i) |=> (mask_o == $past(store_i) && masked_o));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_fall_i && !ras_rise_i) |=> ($stable(mask_o) && $stable(masked_o)));
  assert_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise_i && !ras_fall_i) |=> (mask_o == ONES && !masked_o));
endmodule

// File: rtl/wpb_lane_gate.sv
module wpb_lane_gate #(
  parameter int unsigned W  = 16,
  parameter int unsigned LW = 8,
  localparam int unsigned NL = W / LW
) (
  input  logic [W-1:0]  mask_i,
  input  logic [NL-1:0] lane_i,
  output logic [W-1:0]  wr_en_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign wr_en_o[g*LW +: LW] = mask_i[g*LW +: LW] & {LW{lane_i[g]}};
  end
endmodule

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit #(
  parameter int unsigned DATA_W = wpb_pkg::DATA_W,
  parameter int unsigned LANE_W = wpb_pkg::LANE_W,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_fall_i,
  input  logic              we_low_i,
  input  logic              ras_rise_i,
  input  logic              load_mask_i,
  input  logic              mask_reset_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic [DATA_W-1:0] wr_en_o,
  output logic              persist_mode_o,
  output logic              masked_cycle_o
);
  // Named internal wires so the assertions can see them.
  logic [DATA_W-1:0] stored_mask;
  logic [DATA_W-1:0] cycle_mask;
  logic              sticky;

  wpb_persist_store #(.W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_mask_i), .clear_i(mask_reset_i), .data_i(dq_i),
    .persist_o(sticky), .store_o(stored_mask)
  );

  wpb_cycle_mask #(.W(DATA_W)) u_cycle (
    .clk(clk), .rst_n(rst_n),
    .ras_fall_i(ras_fall_i), .we_low_i(we_low_i), .ras_rise_i(ras_rise_i),
    .persist_i(sticky), .store_i(stored_mask), .dq_i(dq_i),
    .mask_o(cycle_mask), .masked_o(masked_cycle_o)
  );

  wpb_lane_gate #(.W(DATA_W), .LW(LANE_W)) u_gate (
    .mask_i(cycle_mask), .lane_i(lane_en_i), .wr_en_o(wr_en_o)
  );

  assign persist_mode_o = sticky;

  assert_gate_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o & ~cycle_mask) == '0);
  assert_gate_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o & ~wpb_pkg::lane_expand(lane_en_i)) == '0);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!persist_mode_o && !masked_cycle_o && cycle_mask == '1));
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mask_i && mask_reset_i) |=> !persist_mode_o);
endmodule

// File: tb/wpb_mask_unit_test.sv
module wpb_mask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_fall = 1'b0, we_low = 1'b0, ras_rise = 1'b0;
  logic        load_m = 1'b0, mreset = 1'b0;
  logic [15:0] dq = 16'h0000;
  logic [1:0]  lanes = 2'b11;
  logic [15:0] wr_en;
  logic        persist, masked;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wpb_mask_unit uut (
    .clk(clk), .rst_n(rst_n), .ras_fall_i(ras_fall), .we_low_i(we_low),
    .ras_rise_i(ras_rise), .load_mask_i(load_m), .mask_reset_i(mreset),
    .dq_i(dq), .lane_en_i(lanes), .wr_en_o(wr_en),
    .persist_mode_o(persist), .masked_cycle_o(masked)
  );

  // Row layout: {req[3:0], op[2:0], we_low, dq[15:0], lanes[1:0], exp_wr[15:0], exp_persist, exp_masked}
  // op: 0 idle, 1 row fall, 2 row rise, 3 mask load, 4 mask reset, 5 load+reset together
  localparam int NV = 23;
  localparam logic [43:0] VEC [0:NV-1] = '{
    {4'd1, 3'd0,1'b0,16'hFFFF,2'b11,16'hFFFF,1'b0,1'b0}, // R1 idle after reset
    {4'd2, 3'd1,1'b0,16'h1234,2'b11,16'hFFFF,1'b0,1'b0}, // R2 unmasked fall
    {4'd9, 3'd0,1'b0,16'h0000,2'b01,16'h00FF,1'b0,1'b0}, // R9 low lane only
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b0,1'b0}, // R10
    {4'd3, 3'd1,1'b1,16'hA5C3,2'b11,16'hA5C3,1'b0,1'b1}, // R3 capture bus
    {4'd4, 3'd0,1'b0,16'h0000,2'b11,16'hA5C3,1'b0,1'b1}, // R4 bus changes
    {4'd9, 3'd0,1'b0,16'hFFFF,2'b10,16'hA500,1'b0,1'b1}, // R9 high lane only
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b0,1'b0}, // R10
    {4'd5, 3'd3,1'b0,16'h0F0F,2'b11,16'hFFFF,1'b1,1'b0}, // R5 load
    {4'd6, 3'd1,1'b1,16'hFFFF,2'b11,16'h0F0F,1'b1,1'b1}, // R6 stored used
    {4'd9, 3'd0,1'b0,16'h1111,2'b01,16'h000F,1'b1,1'b1}, // R9
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b1,1'b0}, // R10
    {4'd2, 3'd1,1'b0,16'h0000,2'b11,16'hFFFF,1'b1,1'b0}, // R2 unmasked in sticky
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b1,1'b0}, // R10
    {4'd8, 3'd1,1'b1,16'hAAAA,2'b11,16'h0F0F,1'b1,1'b1}, // R8 store intact
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b1,1'b0}, // R10
    {4'd7, 3'd4,1'b0,16'h0000,2'b11,16'hFFFF,1'b0,1'b0}, // R7 mask reset
    {4'd7, 3'd1,1'b1,16'h3C3C,2'b11,16'h3C3C,1'b0,1'b1}, // R7 bus again
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b0,1'b0}, // R10
    {4'd11,3'd5,1'b0,16'h1357,2'b11,16'hFFFF,1'b0,1'b0}, // R11 both pulses
    {4'd11,3'd1,1'b1,16'h8001,2'b11,16'h8001,1'b0,1'b1}, // R11 bus still used
    {4'd10,3'd2,1'b0,16'h0000,2'b11,16'hFFFF,1'b0,1'b0}, // R10
    {4'd9, 3'd0,1'b0,16'hFFFF,2'b00,16'h0000,1'b0,1'b0}  // R9 no lanes
  };

  task automatic check(input string req, input logic [15:0] exp_wr,
                       input logic exp_p, input logic exp_m);
    checks++;
    if (wr_en !== exp_wr || persist !== exp_p || masked !== exp_m) begin
      fails++;
      $display("FAIL %s: wr_en=%h persist=%b masked=%b, expected %h %b %b",
               req, wr_en, persist, masked, exp_wr, exp_p, exp_m);
    end
  endtask

  // Drive on one falling edge, clear the pulses and sample on the next.
  task automatic apply(input logic [2:0] op, input logic w, input logic [15:0] d,
                       input logic [1:0] l);
    @(negedge clk);
    ras_fall = (op == 3'd1);
    ras_rise = (op == 3'd2);
    load_m   = (op == 3'd3) || (op == 3'd5);
    mreset   = (op == 3'd4) || (op == 3'd5);
    we_low   = w; dq = d; lanes = l;
    @(negedge clk);
    ras_fall = 0; ras_rise = 0; load_m = 0; mreset = 0; we_low = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'hFFFF, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][39:37], VEC[i][36], VEC[i][35:20], VEC[i][19:18]);
      check($sformatf("R%0d", VEC[i][43:40]), VEC[i][17:2], VEC[i][1], VEC[i][0]);
    end
    // R1: reset after a mask load drops sticky mode.
    apply(3'd3, 1'b0, 16'h00F0, 2'b11);
    check("R5", 16'hFFFF, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1", 16'hFFFF, 1'b0, 1'b0);
    apply(3'd1, 1'b1, 16'h6606, 2'b11);
    check("R1", 16'h6606, 1'b0, 1'b1);
    // R4: several page accesses with a moving bus keep the mask.
    for (int k = 0; k < 4; k++) begin
      apply(3'd0, 1'b0, 16'h1 << k, 2'b11);
      check("R4", 16'h6606, 1'b0, 1'b1);
    end
    apply(3'd2, 1'b0, 16'h0, 2'b11);
    check("R10", 16'hFFFF, 1'b0, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule